// File: doc/BRIEF.md
# Systolic Top-Five Peak Finder

This block watches a stream of signed samples, each tagged with the memory address it came from, and reports the five largest samples together with their addresses. The work is done by a linear chain of five compare stages. Each stage owns a travelling candidate register and a resident peak register. On every clock the larger of the two stays resident and the smaller moves one stage to the right. Whatever leaves the last stage is either thrown away or, during the readout phase, captured. Larger values therefore settle toward the left of the chain.

A run opens with a start strobe. This clears every register to the most negative two's-complement value, which serves as an empty slot. Samples are then presented with a valid qualifier, and an end strobe closes the run. The block then runs three fixed phases of five cycles each. In the settle phase empty slots are fed in so that the last sample finishes its comparisons. In the flush phase five most-positive sentinels are injected. In the drain phase empty slots are fed again while the peaks leave the chain's right end in ascending order and are shifted into the result registers. Slot 0 then holds the largest pair. A one-cycle done pulse marks the result, which holds until the next start.

Ranking is by value. Among equal values the lower address ranks first. Any real sample ranks above an empty slot, and every sentinel ranks above any real sample, even one equal to the extreme values. When two entries compare exactly equal, the resident one stays.

Top module: `peak5_finder`

## Requirements
- R1: After reset, and in the cycle after any start strobe, done is low and every result slot reads value 0x8000 (most negative) with address 0.
- R2: At done, result slot k (value bits [16k+15:16k], address bits [10k+9:10k]) holds the (k+1)-th largest accepted sample under signed comparison, so slot 0 is the largest.
- R3: Samples of equal value are ordered by ascending address, and a pair accepted twice occupies two slots.
- R4: With fewer than five accepted samples, the unfilled slots read 0x8000 with address 0, and a real sample of value 0x8000 still appears with its own address ahead of them.
- R5: A real sample of value 0x7FFF is reported with its own address, and no sentinel ever appears in a result slot.
- R6: Done is high for exactly one cycle, 15 clock edges after the edge that samples the end strobe.
- R7: A sample whose valid is high in the same cycle as the end strobe is accepted, and cycles with valid low contribute nothing.
- R8: From the edge that samples the end strobe until the next start, valid, data and further end strobes are ignored, and the result slots do not change after done.
- R9: A start strobe discards every sample accepted before it, including a sample presented with valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clear the chain and open a run |
| in_valid_i | input | 1 | Qualifies in_data_i and in_addr_i |
| in_data_i | input | 16 | Signed sample |
| in_addr_i | input | 10 | Address carried with the sample |
| end_i | input | 1 | Closes the run and starts settle, flush and drain |
| res_data_o | output | 80 | Five result values, slot 0 in the low bits |
| res_addr_o | output | 50 | Five result addresses, slot 0 in the low bits |
| done_o | output | 1 | One-cycle pulse when the result is valid |

## Verification
The bench targets the cases where a rank rule is easy to get wrong. Samples equal to the most negative value could be mistaken for empty slots and reported with address 0. Samples equal to the most positive value could be pushed out by the sentinels and replaced with bogus addresses. Runs packed with duplicates expose a wrong tie rule as swapped addresses, and runs shorter than five samples expose bad padding. Timing cases cover a last sample that arrives together with the end strobe, valid traffic during the post-end phases and after done, and restarts in the middle of a run. A design that mishandled these would drop that last sample, take stray samples into the result, or emit a late or stretched done.

// File: rtl/peak5_pkg.sv
package peak5_pkg;

  // Entry class: ordering key is class first, then value, then lower address.
  typedef enum logic [1:0] {
    RK_FILL = 2'd0,
    RK_REAL = 2'd1,
    RK_SENT = 2'd2
  } rank_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUN    = 3'd1,
    ST_SETTLE = 3'd2,
    ST_FLUSH  = 3'd3,
    ST_DRAIN  = 3'd4
  } state_t;

endpackage

// File: rtl/peak5_stage.sv
module peak5_stage
  import peak5_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  rank_t         c_rk_d,
  input  logic [W-1:0]  c_val_d,
  input  logic [AW-1:0] c_addr_d,
  output rank_t         lo_rk,
  output logic [W-1:0]  lo_val,
  output logic [AW-1:0] lo_addr
);

  localparam logic [W-1:0] VMIN = {1'b1, {(W-1){1'b0}}};

  rank_t         c_rk_q, p_rk_q, c_rk_nx, p_rk_nx;
  logic [W-1:0]  c_val_q, p_val_q, c_val_nx, p_val_nx;
  logic [AW-1:0] c_addr_q, p_addr_q, c_addr_nx, p_addr_nx;
  logic          cand_wins;

  // Candidate displaces the resident only when strictly greater.
  always_comb begin
    if (c_rk_q != p_rk_q)
      cand_wins = (c_rk_q > p_rk_q);
    else if (c_val_q != p_val_q)
      cand_wins = ($signed(c_val_q) > $signed(p_val_q));
    else
      cand_wins = (c_addr_q < p_addr_q);
  end

  assign lo_rk   = cand_wins ? p_rk_q   : c_rk_q;
  assign lo_val  = cand_wins ? p_val_q  : c_val_q;
  assign lo_addr = cand_wins ? p_addr_q : c_addr_q;

  always_comb begin
    c_rk_nx = c_rk_q; c_val_nx = c_val_q; c_addr_nx = c_addr_q;
    p_rk_nx = p_rk_q; p_val_nx = p_val_q; p_addr_nx = p_addr_q;
    if (clr) begin
      c_rk_nx = RK_FILL; c_val_nx = VMIN; c_addr_nx = '0;
      p_rk_nx = RK_FILL; p_val_nx = VMIN; p_addr_nx = '0;
    end else if (en) begin
      c_rk_nx = c_rk_d; c_val_nx = c_val_d; c_addr_nx = c_addr_d;
      if (cand_wins) begin
        p_rk_nx = c_rk_q; p_val_nx = c_val_q; p_addr_nx = c_addr_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_rk_q <= RK_FILL; c_val_q <= VMIN; c_addr_q <= '0;
      p_rk_q <= RK_FILL; p_val_q <= VMIN; p_addr_q <= '0;
    end else begin
      c_rk_q <= c_rk_nx; c_val_q <= c_val_nx; c_addr_q <= c_addr_nx;
      p_rk_q <= p_rk_nx; p_val_q <= p_val_nx; p_addr_q <= p_addr_nx;
    end
  end

endmodule

// File: rtl/peak5_ctrl.sv
module peak5_ctrl
  import peak5_pkg::*;
#(
  parameter int N = 5
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  logic  end_i,
  input  logic  in_valid_i,
  output rank_t src_rk,
  output logic  arr_en,
  output logic  arr_clr,
  output logic  cap_en,
  output logic  busy,
  output logic  done_o
);

  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(N - 1);

  state_t        st_q, st_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          done_q, done_nx;
  logic          last;

  assign last = (cnt_q == CNT_LAST);

  always_comb begin
    st_nx   = st_q;
    cnt_nx  = cnt_q;
    done_nx = 1'b0;
    if (start_i) begin
      st_nx  = ST_RUN;
      cnt_nx = '0;
    end else begin
      case (st_q)
        ST_RUN: if (end_i) begin st_nx = ST_SETTLE; cnt_nx = '0; end
        ST_SETTLE: begin
          if (last) begin st_nx = ST_FLUSH; cnt_nx = '0; end
          else cnt_nx = cnt_q + CW'(1);
        end
        ST_FLUSH: begin
          if (last) begin st_nx = ST_DRAIN; cnt_nx = '0; end
          else cnt_nx = cnt_q + CW'(1);
        end
        ST_DRAIN: begin
          if (last) begin st_nx = ST_IDLE; cnt_nx = '0; done_nx = 1'b1; end
          else cnt_nx = cnt_q + CW'(1);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      ST_RUN:   src_rk = in_valid_i ? RK_REAL : RK_FILL;
      ST_FLUSH: src_rk = RK_SENT;
      default:  src_rk = RK_FILL;
    endcase
  end

  assign arr_en  = (st_q != ST_IDLE);
  assign arr_clr = start_i;
  assign cap_en  = (st_q == ST_DRAIN) && !start_i;
  assign busy    = (st_q != ST_IDLE);
  assign done_o  = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_nx;
      cnt_q  <= cnt_nx;
      done_q <= done_nx;
    end
  end

endmodule

// File: rtl/peak5_collect.sv
module peak5_collect
  import peak5_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 10,
  parameter int N  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            cap,
  input  rank_t           ex_rk,
  input  logic [W-1:0]    ex_val,
  input  logic [AW-1:0]   ex_addr,
  output logic [N*W-1:0]  res_data_o,
  output logic [N*AW-1:0] res_addr_o
);

  localparam logic [W-1:0] VMIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0]  sv_q [N];
  logic [W-1:0]  sv_nx [N];
  logic [AW-1:0] sa_q [N];
  logic [AW-1:0] sa_nx [N];
  logic [W-1:0]  in_v;
  logic [AW-1:0] in_a;

  // Only real entries may enter the result; anything else reads as empty.
  assign in_v = (ex_rk == RK_REAL) ? ex_val  : VMIN;
  assign in_a = (ex_rk == RK_REAL) ? ex_addr : '0;

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_slot
      logic [W-1:0]  up_v;
      logic [AW-1:0] up_a;
      if (k == 0) begin : g_head
        assign up_v = in_v;
        assign up_a = in_a;
      end else begin : g_body
        assign up_v = sv_q[k-1];
        assign up_a = sa_q[k-1];
      end

      always_comb begin
        sv_nx[k] = sv_q[k];
        sa_nx[k] = sa_q[k];
        if (clr) begin
          sv_nx[k] = VMIN;
          sa_nx[k] = '0;
        end else if (cap) begin
          sv_nx[k] = up_v;
          sa_nx[k] = up_a;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sv_q[k] <= VMIN;
          sa_q[k] <= '0;
        end else begin
          sv_q[k] <= sv_nx[k];
          sa_q[k] <= sa_nx[k];
        end
      end

      assign res_data_o[k*W +: W]   = sv_q[k];
      assign res_addr_o[k*AW +: AW] = sa_q[k];
    end
  endgenerate

endmodule

// File: rtl/peak5_finder.sv
module peak5_finder
  import peak5_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 10,
  parameter int N  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            in_valid_i,
  input  logic [W-1:0]    in_data_i,
  input  logic [AW-1:0]   in_addr_i,
  input  logic            end_i,
  output logic [N*W-1:0]  res_data_o,
  output logic [N*AW-1:0] res_addr_o,
  output logic            done_o
);

  localparam logic [W-1:0] VMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] VMAX = {1'b0, {(W-1){1'b1}}};

  rank_t         src_rk;
  logic          arr_en, arr_clr, cap_en, busy;
  rank_t         ent_rk   [N+1];
  logic [W-1:0]  ent_val  [N+1];
  logic [AW-1:0] ent_addr [N+1];

  peak5_ctrl #(.N(N)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .end_i      (end_i),
    .in_valid_i (in_valid_i),
    .src_rk     (src_rk),
    .arr_en     (arr_en),
    .arr_clr    (arr_clr),
    .cap_en     (cap_en),
    .busy       (busy),
    .done_o     (done_o)
  );

  // Chain entry: real sample, sentinel (most positive) or empty (most negative).
  always_comb begin
    ent_rk[0] = src_rk;
    case (src_rk)
      RK_REAL: begin ent_val[0] = in_data_i; ent_addr[0] = in_addr_i; end
      RK_SENT: begin ent_val[0] = VMAX;      ent_addr[0] = '0;        end
      default: begin ent_val[0] = VMIN;      ent_addr[0] = '0;        end
    endcase
  end

  genvar n;
  generate
    for (n = 0; n < N; n++) begin : g_stage
      peak5_stage #(.W(W), .AW(AW)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (arr_en),
        .clr      (arr_clr),
        .c_rk_d   (ent_rk[n]),
        .c_val_d  (ent_val[n]),
        .c_addr_d (ent_addr[n]),
        .lo_rk    (ent_rk[n+1]),
        .lo_val   (ent_val[n+1]),
        .lo_addr  (ent_addr[n+1])
      );
    end
  endgenerate

  peak5_collect #(.W(W), .AW(AW), .N(N)) u_collect (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (arr_clr),
    .cap        (cap_en),
    .ex_rk      (ent_rk[N]),
    .ex_val     (ent_val[N]),
    .ex_addr    (ent_addr[N]),
    .res_data_o (res_data_o),
    .res_addr_o (res_addr_o)
  );

endmodule

// File: rtl/peak5_finder_chk.sv
module peak5_finder_chk #(
  parameter int W  = 16,
  parameter int AW = 10,
  parameter int N  = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            busy,
  input logic            done_o,
  input logic [N*W-1:0]  res_data_o,
  input logic [N*AW-1:0] res_addr_o
);

  localparam logic [W-1:0]    VMIN    = {1'b1, {(W-1){1'b0}}};
  localparam logic [N*W-1:0]  ALL_MIN = {N{VMIN}};

  // R1: a start strobe leaves empty slots and no done behind it
  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_o && res_data_o == ALL_MIN && res_addr_o == '0));

  // R6: done lasts a single cycle
  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: done only follows a collecting cycle
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(busy));

  // R8: results hold while idle
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_i) |=> ($stable(res_data_o) && $stable(res_addr_o)));

  // R2: slots are in descending value order when done is raised
  genvar k;
  generate
    for (k = 0; k + 1 < N; k++) begin : g_desc
      a_r2_slots_descending: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($signed(res_data_o[k*W +: W]) >= $signed(res_data_o[(k+1)*W +: W])));
    end
  endgenerate

endmodule

bind peak5_finder peak5_finder_chk #(.W(W), .AW(AW), .N(N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy       (busy),
  .done_o     (done_o),
  .res_data_o (res_data_o),
  .res_addr_o (res_addr_o)
);

// File: tb/tb_peak5_finder.sv
module tb_peak5_finder;

  localparam int W  = 16;
  localparam int AW = 10;
  localparam int NS = 5;
  localparam int CLK_PERIOD = 10;
  localparam int VMIN = -(1 << (W-1));
  localparam int VMAX = (1 << (W-1)) - 1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start_i, in_valid_i, end_i;
  logic [W-1:0]    in_data_i;
  logic [AW-1:0]   in_addr_i;
  logic [NS*W-1:0] res_data_o;
  logic [NS*AW-1:0] res_addr_o;
  logic            done_o;

  int nchk = 0;
  int nerr = 0;

  int sv [0:63];
  int sa [0:63];
  int ns;
  int exp_v [NS];
  int exp_a [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  peak5_finder #(.W(W), .AW(AW), .N(NS)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
    .in_data_i(in_data_i), .in_addr_i(in_addr_i), .end_i(end_i),
    .res_data_o(res_data_o), .res_addr_o(res_addr_o), .done_o(done_o)
  );

  function automatic int slot_v(int k);
    return $signed(res_data_o[k*W +: W]);
  endfunction

  function automatic int slot_a(int k);
    return int'(res_addr_o[k*AW +: AW]);
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Reference: descending by value, ties by lower address, pad with empty slots.
  task automatic calc_expected();
    bit used [0:63];
    for (int i = 0; i < 64; i++) used[i] = 1'b0;
    for (int s = 0; s < NS; s++) begin
      int best = -1;
      for (int i = 0; i < ns; i++) begin
        if (!used[i] && (best < 0 || sv[i] > sv[best] ||
            (sv[i] == sv[best] && sa[i] < sa[best])))
          best = i;
      end
      if (best >= 0) begin
        used[best] = 1'b1;
        exp_v[s] = sv[best];
        exp_a[s] = sa[best];
      end else begin
        exp_v[s] = VMIN;
        exp_a[s] = 0;
      end
    end
  endtask

  task automatic cmp_results(input string req);
    int bad = -1;
    calc_expected();
    for (int k = 0; k < NS; k++)
      if (bad < 0 && (slot_v(k) != exp_v[k] || slot_a(k) != exp_a[k])) bad = k;
    nchk++;
    if (bad >= 0) begin
      nerr++;
      $display("FAIL %s slot %0d actual=(%0d,%0d) expected=(%0d,%0d)", req, bad,
               slot_v(bad), slot_a(bad), exp_v[bad], exp_a[bad]);
    end
  endtask

  task automatic check_empty(input string req);
    int bad = 0;
    for (int k = 0; k < NS; k++)
      if (slot_v(k) != VMIN || slot_a(k) != 0) bad++;
    check(bad == 0 && !done_o, req, "empty slots after clear", bad, 0);
  endtask

  task automatic begin_run(input bit with_valid);
    start_i = 1'b1;
    in_valid_i = with_valid;
    in_data_i = W'(VMAX);
    in_addr_i = AW'(77);
    @(negedge clk);
    start_i = 1'b0;
    in_valid_i = 1'b0;
    ns = 0;
  endtask

  task automatic push(input int v, input int a);
    in_valid_i = 1'b1;
    in_data_i = W'(v);
    in_addr_i = AW'(a);
    if (ns < 64) begin
      sv[ns] = $signed(W'(v));
      sa[ns] = a % (1 << AW);
      ns++;
    end
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  task automatic idle_cycle();
    in_valid_i = 1'b0;
    in_data_i = W'($urandom);
    @(negedge clk);
  endtask

  task automatic finish_run(input bit last_valid, input int lv, input int la,
                            input bit noise, input string req);
    int lat = -1;
    end_i = 1'b1;
    in_valid_i = last_valid;
    in_data_i = W'(lv);
    in_addr_i = AW'(la);
    if (last_valid && ns < 64) begin
      sv[ns] = $signed(W'(lv));
      sa[ns] = la % (1 << AW);
      ns++;
    end
    @(negedge clk);
    end_i = 1'b0;
    in_valid_i = 1'b0;
    for (int j = 1; j <= 60; j++) begin
      if (done_o) begin
        lat = j - 1;
        break;
      end
      if (noise) begin
        in_valid_i = 1'b1;
        in_data_i = W'(VMAX - 1);
        in_addr_i = AW'($urandom);
        end_i = ($urandom_range(0, 3) == 0);
      end
      @(negedge clk);
    end
    in_valid_i = 1'b0;
    end_i = 1'b0;
    check(lat == 3*NS, "R6", "done latency", lat, 3*NS);
    cmp_results(req);
    @(negedge clk);
    check(!done_o, "R6", "done width", int'(done_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    rst_n = 1'b0;
    start_i = 1'b0; in_valid_i = 1'b0; end_i = 1'b0;
    in_data_i = '0; in_addr_i = '0;
    ns = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check_empty("R1");

    // R4: empty run
    begin_run(1'b0);
    check_empty("R1");
    finish_run(1'b0, 0, 0, 1'b0, "R4");

    // R4, R2: three samples, one negative
    begin_run(1'b0);
    push(5, 11); push(-2, 12); idle_cycle(); push(100, 13);
    finish_run(1'b0, 0, 0, 1'b0, "R4");

    // R4: real most-negative samples rank above empty slots
    begin_run(1'b0);
    push(VMIN, 7); push(VMIN, 3);
    finish_run(1'b0, 0, 0, 1'b0, "R4");

    // R5, R7: most-positive real samples, last sample arrives with end strobe
    begin_run(1'b0);
    push(VMAX, 40); push(3, 1); push(VMAX, 9); idle_cycle(); push(-7, 2);
    push(VMAX, 500); push(12, 4);
    finish_run(1'b1, VMAX - 1, 33, 1'b0, "R5");

    // R7: the sample with the end strobe is the largest
    begin_run(1'b0);
    push(1, 1); push(2, 2); push(3, 3); push(4, 4); push(5, 5); push(6, 6);
    finish_run(1'b1, 1000, 99, 1'b0, "R7");

    // R3: duplicates, including an identical pair
    begin_run(1'b0);
    push(4, 9); push(4, 2); push(1, 8); push(4, 5); push(4, 2); push(0, 1);
    finish_run(1'b0, 0, 0, 1'b0, "R3");

    // R8: valid traffic and end strobes after the end strobe are ignored
    begin_run(1'b0);
    push(10, 1); push(20, 2); push(-30, 3);
    finish_run(1'b0, 0, 0, 1'b1, "R8");

    // R8: after done, inputs are ignored and results hold
    begin
      int snap_v [NS];
      int snap_a [NS];
      int seen = 0;
      int diff = 0;
      for (int k = 0; k < NS; k++) begin
        snap_v[k] = slot_v(k);
        snap_a[k] = slot_a(k);
      end
      for (int i = 0; i < 6; i++) begin
        in_valid_i = 1'b1;
        in_data_i = W'(VMAX);
        in_addr_i = AW'(i);
        end_i = (i == 3);
        @(negedge clk);
      end
      in_valid_i = 1'b0;
      end_i = 1'b0;
      for (int j = 0; j < 25; j++) begin
        if (done_o) seen++;
        @(negedge clk);
      end
      for (int k = 0; k < NS; k++)
        if (slot_v(k) != snap_v[k] || slot_a(k) != snap_a[k]) diff++;
      check(seen == 0, "R8", "done while idle", seen, 0);
      check(diff == 0, "R8", "changed slots while idle", diff, 0);
    end

    // R9: restart mid-run discards earlier samples
    begin_run(1'b0);
    push(900, 1); push(800, 2); push(700, 3);
    begin_run(1'b0);
    check_empty("R9");
    push(-5, 20); push(6, 21);
    finish_run(1'b0, 0, 0, 1'b0, "R9");

    // R9: a sample presented together with start is dropped
    begin_run(1'b1);
    finish_run(1'b0, 0, 0, 1'b0, "R9");

    // R2: random runs with gaps and several value patterns
    for (int r = 0; r < 12; r++) begin
      int len = $urandom_range(0, 40);
      int mode = r % 3;
      begin_run(1'b0);
      for (int i = 0; i < len; i++) begin
        int v;
        int a;
        if ($urandom_range(0, 3) == 0) idle_cycle();
        case (mode)
          0: v = $signed(W'($urandom));
          1: v = $urandom_range(0, 6) - 3;
          default: begin
            case ($urandom_range(0, 4))
              0: v = VMIN;
              1: v = VMAX;
              2: v = 0;
              3: v = VMIN + 1;
              default: v = VMAX - 1;
            endcase
          end
        endcase
        a = (mode == 1) ? $urandom_range(0, 7) : $urandom_range(0, (1 << AW) - 1);
        push(v, a);
      end
      finish_run(1'b0, 0, 0, 1'b0, "R2");
    end

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule